// File: doc/BRIEF.md
# Flash controller interrupt register bank

This block holds the interrupt state of a quad-SPI flash controller. Six event sources arrive as inputs: level flags from the transmit and receive FIFOs (receive not empty, receive full, transmit full, transmit below watermark) and one-cycle error pulses (receive overflow, transmit underflow). Each source latches into a status register. Software reads that register and acknowledges bits by writing ones to them.

Two write-only ports edit an enable mask. A write to the set port turns mask bits on, and a write to the clear port turns them off. The mask itself is visible through a separate read-only view. A registered, level-sensitive interrupt line is high while any latched status bit is also enabled. Access goes through a simple single-cycle 32-bit register bus. Reads have no side effects, and read data is combinational from the addressed register.

Top module: `qirq_top`

## Requirements
- R1: All four registers share one bit layout: bit 0 receive overflow, bit 2 transmit below watermark, bit 3 transmit full, bit 4 receive not empty, bit 5 receive full, bit 6 transmit underflow. Bits 1 and 7..31 always read 0 in status and mask.
- R2: Status is read at offset 0x04. Writing 1 to a status bit clears it on the next clock edge if its source is inactive. Bits written with 0 keep their value.
- R3: Writing back the status value just read acknowledges every pending source whose condition has gone away, and status then reads 0.
- R4: Status bit 2 sets whenever tx_level_i is strictly less than tx_wmark_i. It does not set when the two are equal.
- R5: A write to offset 0x08 ORs the written defined bits into the mask. A write to offset 0x0C clears the mask bits written as 1. Bits written as 0 are unchanged.
- R6: The mask reads at offset 0x10. Offsets 0x08 and 0x0C read as 0.
- R7: Overflow (bit 0) and underflow (bit 6) latch on a one-cycle event pulse and stay set until cleared by a write of 1.
- R8: A level bit (2, 3, 4, 5) whose condition still holds stays set after a write-one clear, because setting wins over clearing. Once set, it stays latched after its condition drops, until it is cleared.
- R9: irq_o is a register that is high one cycle after any bit is set in both status and mask, and low one cycle after no bit is.
- R10: After reset, status, mask and irq_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (8) | Byte offset |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data, valid while req_i and not we_i |
| rx_ovf_evt_i | input | 1 | Receive overflow event pulse |
| tx_udf_evt_i | input | 1 | Transmit underflow event pulse |
| tx_full_i | input | 1 | Transmit FIFO full level |
| rx_nempty_i | input | 1 | Receive FIFO not empty level |
| rx_full_i | input | 1 | Receive FIFO full level |
| tx_level_i | input | LW (7) | Transmit FIFO fill count |
| tx_wmark_i | input | LW (7) | Transmit watermark |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that error events arrive as single-cycle pulses, that a bus access lasts exactly one cycle, and that an access is either a read or a write. The bench drives every access from one task that holds req_i for one clock, and it raises each event input for one cycle only. Level inputs change only between accesses, so any read or irq sample happens after the previous change has been captured.

// File: rtl/qirq_pkg.sv
package qirq_pkg;
  localparam int NSRC = 7;
  localparam int B_RX_OVF = 0;
  localparam int B_TX_LOW = 2;
  localparam int B_TX_FULL = 3;
  localparam int B_RX_NE = 4;
  localparam int B_RX_FULL = 5;
  localparam int B_TX_UDF = 6;
  localparam logic [NSRC-1:0] VALID_BITS = 7'b111_1101;
  localparam logic [7:0] OFF_STS = 8'h04;
  localparam logic [7:0] OFF_EN = 8'h08;
  localparam logic [7:0] OFF_DIS = 8'h0C;
  localparam logic [7:0] OFF_MSK = 8'h10;
endpackage

// File: rtl/qirq_src.sv
module qirq_src
  import qirq_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic            rx_ovf_evt_i,
  input  logic            tx_udf_evt_i,
  input  logic            tx_full_i,
  input  logic            rx_nempty_i,
  input  logic            rx_full_i,
  input  logic [LW-1:0]   tx_level_i,
  input  logic [LW-1:0]   tx_wmark_i,
  output logic [NSRC-1:0] set_o
);
  always_comb begin
    set_o = '0;
    set_o[B_RX_OVF]  = rx_ovf_evt_i;
    set_o[B_TX_LOW]  = tx_level_i < tx_wmark_i;
    set_o[B_TX_FULL] = tx_full_i;
    set_o[B_RX_NE]   = rx_nempty_i;
    set_o[B_RX_FULL] = rx_full_i;
    set_o[B_TX_UDF]  = tx_udf_evt_i;
  end
endmodule

// File: rtl/qirq_status.sv
module qirq_status #(
  parameter int N = 7,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  // set beats clear so live levels re-latch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= ((sts_q & ~clr_i) | set_i) & VALID;
  end
  assign sts_o = sts_q;

  // R7
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & ~$past(clr_i)) & $past(sts_q)) == ($past(sts_q) & ~$past(clr_i)));
  // R8
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & VALID) != '0) |=> ((sts_q & $past(set_i & VALID)) == $past(set_i & VALID)));
  // R2
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/qirq_mask.sv
module qirq_mask #(
  parameter int N = 7,
  parameter logic [N-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] dis_i,
  output logic [N-1:0] msk_o
);
  logic [N-1:0] msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) msk_q <= '0;
    else         msk_q <= (msk_q | en_i) & ~dis_i & VALID;
  end
  assign msk_o = msk_q;

  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((en_i & VALID) != '0 && dis_i == '0) |=> ((msk_q & $past(en_i & VALID)) == $past(en_i & VALID)));
  // R5
  mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_i != '0) |=> ((msk_q & $past(dis_i)) == '0));
endmodule

// File: rtl/qirq_top.sv
module qirq_top
  import qirq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int LW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_ovf_evt_i,
  input  logic          tx_udf_evt_i,
  input  logic          tx_full_i,
  input  logic          rx_nempty_i,
  input  logic          rx_full_i,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] tx_wmark_i,
  output logic          irq_o
);
  logic [NSRC-1:0] set_v, clr_v, en_v, dis_v, sts, msk;
  logic wr, rd, irq_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign clr_v = (wr && addr_i == AW'(OFF_STS)) ? wdata_i[NSRC-1:0] : '0;
  assign en_v  = (wr && addr_i == AW'(OFF_EN))  ? wdata_i[NSRC-1:0] & VALID_BITS : '0;
  assign dis_v = (wr && addr_i == AW'(OFF_DIS)) ? wdata_i[NSRC-1:0] : '0;

  qirq_src #(.LW(LW)) u_src (
    .rx_ovf_evt_i(rx_ovf_evt_i), .tx_udf_evt_i(tx_udf_evt_i),
    .tx_full_i(tx_full_i), .rx_nempty_i(rx_nempty_i), .rx_full_i(rx_full_i),
    .tx_level_i(tx_level_i), .tx_wmark_i(tx_wmark_i), .set_o(set_v)
  );

  qirq_status #(.N(NSRC), .VALID(VALID_BITS)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .clr_i(clr_v), .sts_o(sts)
  );

  qirq_mask #(.N(NSRC), .VALID(VALID_BITS)) u_msk (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_v), .dis_i(dis_v), .msk_o(msk)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i == AW'(OFF_STS))      rdata_o = DW'(sts);
      else if (addr_i == AW'(OFF_MSK)) rdata_o = DW'(msk);
    end
  end

  // registered to keep the request line glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(sts & msk);
  end
  assign irq_o = irq_q;

  // R9
  irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(sts & msk) != '0));
  // R6
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (addr_i == AW'(OFF_EN) || addr_i == AW'(OFF_DIS))) |-> (rdata_o == '0));
  // R1
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |-> (rdata_o[1] == 1'b0 && rdata_o[DW-1:NSRC] == '0));
endmodule

// File: tb/sim_qirq_top.sv
module sim_qirq_top;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic ovf = 0, udf = 0, txf = 0, rxne = 0, rxf = 0, irq;
  logic [6:0] lvl = 0, wm = 0;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  qirq_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rx_ovf_evt_i(ovf), .tx_udf_evt_i(udf),
    .tx_full_i(txf), .rx_nempty_i(rxne), .rx_full_i(rxf),
    .tx_level_i(lvl), .tx_wmark_i(wm), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against expected queue
  always @(negedge clk) begin
    if (req && !we) begin
      if (exp_q.size() == 0) check("read without expectation", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    cyc(); req = 1; we = 1; addr = a; wdata = d;
    cyc(); req = 0; we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string tag);
    cyc(); exp_q.push_back(e); tag_q.push_back(tag); req = 1; we = 0; addr = a;
    cyc(); req = 0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R10 reset state
    rd(8'h04, 32'h0, "R10 status after reset");
    rd(8'h10, 32'h0, "R10 mask after reset");
    check("R10 irq after reset", 32'(irq), 32'h0);

    // R1 / R2 level latch and clear
    cyc(); rxne = 1;
    rd(8'h04, 32'h10, "R1 rx not empty bit 4");
    cyc(); rxne = 0;
    rd(8'h04, 32'h10, "R8 latched after level drops");
    wr(8'h04, 32'h10);
    rd(8'h04, 32'h0, "R2 write-one clear");

    // R8 clear while condition holds
    cyc(); rxf = 1;
    wr(8'h04, 32'h20);
    rd(8'h04, 32'h20, "R8 rx full re-latched");
    cyc(); rxf = 0;
    wr(8'h04, 32'h20);
    rd(8'h04, 32'h0, "R8 cleared after drop");

    // R7 sticky events
    cyc(); ovf = 1; cyc(); ovf = 0;
    repeat (3) cyc();
    rd(8'h04, 32'h01, "R7 overflow sticky");
    cyc(); udf = 1; cyc(); udf = 0;
    rd(8'h04, 32'h41, "R7 underflow sticky");
    wr(8'h04, 32'h40);
    rd(8'h04, 32'h01, "R2 selective clear");
    wr(8'h04, 32'h01);
    rd(8'h04, 32'h0, "R2 overflow cleared");

    // R4 watermark
    cyc(); wm = 7'd4; lvl = 7'd4;
    rd(8'h04, 32'h0, "R4 level equal to watermark");
    cyc(); lvl = 7'd3;
    rd(8'h04, 32'h04, "R4 level below watermark");
    cyc(); lvl = 7'd8;
    wr(8'h04, 32'h04);
    rd(8'h04, 32'h0, "R4 cleared above watermark");

    // R5 / R6 mask
    wr(8'h08, 32'h0C);
    rd(8'h10, 32'h0C, "R5 enable sets");
    wr(8'h08, 32'h30);
    rd(8'h10, 32'h3C, "R5 enable ORs");
    wr(8'h0C, 32'h08);
    rd(8'h10, 32'h34, "R5 disable clears");
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h10, 32'h7D, "R1 mask reserved bits zero");
    rd(8'h08, 32'h0, "R6 enable port reads zero");
    rd(8'h0C, 32'h0, "R6 disable port reads zero");
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R5 disable all");

    // R9 interrupt
    cyc(); txf = 1;
    rd(8'h04, 32'h08, "R1 tx full bit 3");
    check("R9 irq masked off", 32'(irq), 32'h0);
    wr(8'h08, 32'h08);
    check("R9 irq one-cycle latency", 32'(irq), 32'h0);
    cyc();
    check("R9 irq asserted", 32'(irq), 32'h1);
    txf = 0;
    wr(8'h04, 32'h08);
    check("R9 irq held one cycle after clear", 32'(irq), 32'h1);
    cyc();
    check("R9 irq dropped", 32'(irq), 32'h0);

    // R3 write back what was read
    cyc(); ovf = 1; udf = 1; rxne = 1; cyc(); ovf = 0; udf = 0; rxne = 0;
    rd(8'h04, 32'h51, "R3 pending set");
    wr(8'h04, 32'h51);
    rd(8'h04, 32'h0, "R3 all acknowledged");
    check("R3 irq quiet", 32'(irq), 32'h0);

    repeat (2) cyc();
    check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule